// File: doc/BRIEF.md
# BCD Calendar Real-Time Counter

This block keeps the date and the time of day as packed BCD bytes: seconds, minutes, hours (24-hour only), day of month, month and a two-digit year that stands for 2000 to 2099. A 32.768 kHz tick enable, sampled in the system clock domain, is divided down to one carry per second. That carry ripples through a full Gregorian calendar with leap years, and no binary-to-BCD conversion takes place.

A byte-wide register bus gives access to every field, to a control byte that holds the run bit and to a status byte. The status byte shows a live busy flag ahead of each update instant, a running flag and four sticky rollover events. The host clears an event by writing a 1 to it. Time fields can be loaded one at a time, in any order, either while the counter is stopped or in the safe window after busy falls. Each write takes effect on the next clock edge.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01 and year 0x00, and the control byte (0x40) and status byte (0x44) read 0x00.
- R2: While control bit 0 is 1, seconds advance by one for every TICK_DIV tick enables. While it is 0 no field changes, the prescaler is held at zero and status bit 1 reads 0. Status bit 1 reads 1 while the counter runs.
- R3: Seconds and minutes count in BCD (0x09 to 0x10) and wrap from 0x59 to 0x00, carrying into the next field.
- R4: Hours count 0x00 to 0x23 and wrap to 0x00, carrying into the day. Only 24-hour mode exists: control bit 3 reads 0 whatever is written to it.
- R5: The day wraps to 0x01 after 0x30 in April, June, September and November, and after 0x31 in the other months apart from February. Month 0x12 wraps to 0x01 and carries into the year, and year 0x99 wraps to 0x00.
- R6: February ends at 0x29 when the year value is divisible by 4, and at 0x28 otherwise.
- R7: Status bit 0 (busy) is 1 from the moment the prescaler reaches its final count until the tick enable that advances seconds. It stays 1 however long that tick is delayed, and it is never 1 while the counter is stopped.
- R8: Status bits 2, 3, 4 and 5 are set on every seconds advance, on the minutes advance, on the hours advance and on the day advance respectively. Each bit then stays set.
- R9: Writing the status byte clears each event bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. An event in the same cycle wins over a clear.
- R10: A write to offset 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 loads seconds, minutes, hours, day, month or year respectively. The new value reads back on the next cycle, in any order and also while running, and the prescaler phase is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | One-cycle enable per 32.768 kHz period |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Byte offset of the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |

## Verification
A wrong carry decision shows up at the ports on the first seconds advance that crosses the affected boundary. The bench therefore preloads each field just below a wrap (minute, hour, 30/31-day month ends, leap and common February, year end) and reads every field back one cycle after that advance. A prescaler phase error shifts the busy flag and the seconds step by whole ticks. The bench catches this by parking the count on its final value and checking that busy holds and seconds stay put until the next tick. A flag that does not stick, or that clears the wrong bit, appears in the status byte at the first read after the event or after the clearing write.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FLD_W = 8;
  localparam int NEVT  = 4;

  localparam logic [7:0] OFS_SEC  = 8'h00;
  localparam logic [7:0] OFS_MIN  = 8'h04;
  localparam logic [7:0] OFS_HOUR = 8'h08;
  localparam logic [7:0] OFS_DAY  = 8'h0C;
  localparam logic [7:0] OFS_MON  = 8'h10;
  localparam logic [7:0] OFS_YEAR = 8'h14;
  localparam logic [7:0] OFS_CTRL = 8'h40;
  localparam logic [7:0] OFS_STAT = 8'h44;

  localparam int ST_BUSY = 0;
  localparam int ST_RUN  = 1;
  localparam int ST_EVT0 = 2;

  typedef enum logic [2:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2,
    F_DAY = 3'd3, F_MON = 3'd4, F_YEAR = 3'd5
  } fld_e;

  typedef struct packed {
    logic [FLD_W-1:0] year;
    logic [FLD_W-1:0] mon;
    logic [FLD_W-1:0] day;
    logic [FLD_W-1:0] hour;
    logic [FLD_W-1:0] min;
    logic [FLD_W-1:0] sec;
  } cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4 in BCD: tens even -> units 0/4/8, tens odd -> units 2/6
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_en_i,
  output logic busy_o,
  output logic sec_tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (tick_en_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  assign busy_o     = run_i && (cnt_q == LAST);
  assign sec_tick_o = busy_o && tick_en_i;

  // R2
  stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  // R7
  tick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !busy_o);
  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_en_i && (cnt_q != LAST)) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sec_tick_i,
  input  logic            wr_i,
  input  fld_e            wr_fld_i,
  input  logic [7:0]      wdata_i,
  output cal_t            cal_o,
  output logic [NEVT-1:0] evt_o
);
  cal_t cal_q, cal_d;
  logic c_sec, c_min, c_hour, c_day, c_mon;

  always_comb begin
    c_sec  = sec_tick_i && (cal_q.sec == 8'h59);
    c_min  = c_sec && (cal_q.min == 8'h59);
    c_hour = c_min && (cal_q.hour == 8'h23);
    c_day  = c_hour && (cal_q.day == month_end(cal_q.mon, cal_q.year));
    c_mon  = c_day && (cal_q.mon == 8'h12);

    cal_d = cal_q;
    if (sec_tick_i) cal_d.sec  = c_sec  ? 8'h00 : bcd_inc(cal_q.sec);
    if (c_sec)      cal_d.min  = c_min  ? 8'h00 : bcd_inc(cal_q.min);
    if (c_min)      cal_d.hour = c_hour ? 8'h00 : bcd_inc(cal_q.hour);
    if (c_hour)     cal_d.day  = c_day  ? 8'h01 : bcd_inc(cal_q.day);
    if (c_day)      cal_d.mon  = c_mon  ? 8'h01 : bcd_inc(cal_q.mon);
    if (c_mon)      cal_d.year = (cal_q.year == 8'h99) ? 8'h00 : bcd_inc(cal_q.year);

    // host load wins for its own field only
    if (wr_i) begin
      case (wr_fld_i)
        F_SEC:   cal_d.sec  = wdata_i;
        F_MIN:   cal_d.min  = wdata_i;
        F_HOUR:  cal_d.hour = wdata_i;
        F_DAY:   cal_d.day  = wdata_i;
        F_MON:   cal_d.mon  = wdata_i;
        default: cal_d.year = wdata_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cal_q <= '{year: 8'h00, mon: 8'h01, day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};
    else         cal_q <= cal_d;
  end

  assign cal_o = cal_q;
  assign evt_o = {c_hour, c_min, c_sec, sec_tick_i};

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_tick_i && !wr_i) |=> $stable(cal_q));
  // R3
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && !wr_i && (cal_q.sec == 8'h59)) |=> (cal_q.sec == 8'h00));
  // R4
  hour_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_hour && !wr_i) |=> (cal_q.hour == 8'h00));
endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flags_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    flag_q <= 1'b0;
      else if (evt_i[k])              flag_q <= 1'b1;
      else if (clr_i && clr_mask_i[k]) flag_q <= 1'b0;
    end
    assign flags_o[k] = flag_q;

    // R8
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> flag_q);
    // R9
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !(clr_i && clr_mask_i[k])) |=> flag_q);
  end
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_cal_pkg::*;
#(
  parameter int TICK_DIV = 32768,
  parameter int AW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam logic [AW-1:0] A_LIM  = AW'(OFS_YEAR);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);

  logic            run_q, busy, sec_tick;
  logic            fld_hit, fld_wr, stat_wr;
  fld_e            fld;
  cal_t            cal;
  logic [NEVT-1:0] evt, flags;

  assign fld_hit = (addr_i <= A_LIM) && (addr_i[1:0] == 2'b00);
  assign fld     = fld_e'(addr_i[4:2]);
  assign fld_wr  = wr_en_i && fld_hit;
  assign stat_wr = wr_en_i && (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              run_q <= 1'b0;
    else if (wr_en_i && (addr_i == A_CTRL))   run_q <= wdata_i[0];
  end

  rtc_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk_i, .rst_ni, .run_i(run_q), .tick_en_i,
    .busy_o(busy), .sec_tick_o(sec_tick)
  );

  rtc_calendar u_cal (
    .clk_i, .rst_ni, .sec_tick_i(sec_tick), .wr_i(fld_wr),
    .wr_fld_i(fld), .wdata_i, .cal_o(cal), .evt_o(evt)
  );

  rtc_event_flags #(.N(NEVT)) u_flags (
    .clk_i, .rst_ni, .evt_i(evt), .clr_i(stat_wr),
    .clr_mask_i(wdata_i[ST_EVT0 +: NEVT]), .flags_o(flags)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (fld_hit) begin
      case (fld)
        F_SEC:   rdata_o = cal.sec;
        F_MIN:   rdata_o = cal.min;
        F_HOUR:  rdata_o = cal.hour;
        F_DAY:   rdata_o = cal.day;
        F_MON:   rdata_o = cal.mon;
        default: rdata_o = cal.year;
      endcase
    end else if (addr_i == A_CTRL) begin
      rdata_o[0] = run_q;
    end else if (addr_i == A_STAT) begin
      rdata_o[ST_BUSY]            = busy;
      rdata_o[ST_RUN]             = run_q;
      rdata_o[ST_EVT0 +: NEVT]    = flags;
    end
  end

  // R7
  no_busy_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !(wr_en_i && (addr_i == A_CTRL))) |=> !busy);
endmodule

// File: tb/tb_rtc_bcd_clock.sv
module tb_rtc_bcd_clock;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    string      req;
    string      what;
    logic [7:0] got;
    logic [7:0] exp;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #5 clk = ~clk;

  rtc_bcd_clock #(.TICK_DIV(DIV), .AW(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // monitor: compares queued observations against expectations
  initial begin
    forever begin
      @(posedge clk);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (it.got !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s: got %h expected %h", it.req, it.what, it.got, it.exp);
        end
      end
    end
  end

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req, input string what);
    @(negedge clk);
    addr = a;
    #1;
    sb_q.push_back('{req: req, what: what, got: rdata, exp: e});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
    wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
  endtask

  task automatic chk_time(input logic [7:0] y, mo, d, h, mi, s, input string req);
    rd_chk(8'h14, y,  req, "year");
    rd_chk(8'h10, mo, req, "month");
    rd_chk(8'h0C, d,  req, "day");
    rd_chk(8'h08, h,  req, "hour");
    rd_chk(8'h04, mi, req, "minute");
    rd_chk(8'h00, s,  req, "second");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R1");
    rd_chk(8'h40, 8'h00, "R1", "ctrl");
    rd_chk(8'h44, 8'h00, "R1", "status");

    // R2 stopped counter ignores ticks
    ticks(8);
    rd_chk(8'h00, 8'h00, "R2", "second while stopped");
    rd_chk(8'h44, 8'h00, "R2", "status while stopped");

    // R10 field loads read back
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58);
    chk_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58, "R10");

    // R2 start
    wr(8'h40, 8'h01);
    rd_chk(8'h40, 8'h01, "R2", "ctrl run");
    rd_chk(8'h44, 8'h02, "R2", "status running");

    // R3 one second
    ticks(DIV);
    rd_chk(8'h00, 8'h59, "R3", "second step");
    rd_chk(8'h44, 8'h06, "R8", "second event");

    // R6 leap February, R4 hour wrap, R8 all events
    ticks(DIV);
    chk_time(8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00, "R6");
    rd_chk(8'h44, 8'h3E, "R8", "all events sticky");

    // R9 write-one-to-clear
    wr(8'h44, 8'h04);
    rd_chk(8'h44, 8'h3A, "R9", "clear second flag");
    wr(8'h44, 8'h00);
    rd_chk(8'h44, 8'h3A, "R9", "zero write no effect");
    wr(8'h44, 8'h38);
    rd_chk(8'h44, 8'h02, "R9", "clear rest");

    // R7 busy on final prescaler count, held while tick delayed
    ticks(DIV - 1);
    rd_chk(8'h44, 8'h03, "R7", "busy raised");
    rd_chk(8'h00, 8'h00, "R7", "second before update");
    repeat (3) @(negedge clk);
    rd_chk(8'h44, 8'h03, "R7", "busy held");
    ticks(1);
    rd_chk(8'h00, 8'h01, "R7", "second after update");
    rd_chk(8'h44, 8'h06, "R7", "busy dropped");

    // R2 stop
    wr(8'h40, 8'h00);
    rd_chk(8'h44, 8'h04, "R2", "status stopped");
    ticks(8);
    rd_chk(8'h00, 8'h01, "R2", "hold while stopped");

    // R6 common-year February
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    wr(8'h40, 8'h01);
    ticks(DIV);
    chk_time(8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, "R6");

    // R5 year end
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    chk_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R5");

    // R5 30-day month
    set_time(8'h21, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    chk_time(8'h21, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00, "R5");

    // R5 31-day month does not wrap at 30
    set_time(8'h21, 8'h05, 8'h30, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    chk_time(8'h21, 8'h05, 8'h31, 8'h00, 8'h00, 8'h00, "R5");

    // R3 BCD digit carry in seconds and minutes
    set_time(8'h21, 8'h05, 8'h31, 8'h10, 8'h19, 8'h09);
    ticks(DIV);
    rd_chk(8'h00, 8'h10, "R3", "second 09->10");
    rd_chk(8'h04, 8'h19, "R3", "minute unchanged");
    wr(8'h04, 8'h09); wr(8'h00, 8'h59);
    ticks(DIV);
    rd_chk(8'h04, 8'h10, "R3", "minute 09->10");
    rd_chk(8'h00, 8'h00, "R3", "second wrap");

    // R4 hour BCD step and 24-hour only
    set_time(8'h21, 8'h05, 8'h31, 8'h09, 8'h59, 8'h59);
    ticks(DIV);
    rd_chk(8'h08, 8'h10, "R4", "hour 09->10");
    wr(8'h40, 8'h09);
    rd_chk(8'h40, 8'h01, "R4", "mode bit ignored");

    // R10 load mid-second keeps prescaler phase
    ticks(2);
    wr(8'h00, 8'h30);
    rd_chk(8'h00, 8'h30, "R10", "second load running");
    ticks(DIV - 2);
    rd_chk(8'h00, 8'h31, "R10", "phase kept");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule